// File: doc/BRIEF.md
# Tag-Wakeup Operation Holding Station

This block buffers issued operations for one functional-unit class of an out-of-order core until their source operands exist. Every operand arrives either as a ready value or as the tag of the station entry that will later produce it. The entry then waits on the result broadcast bus. When a broadcast carries the awaited tag, the entry copies the value and clears the tag. An entry with no outstanding tag is offered to the functional unit, and the unit's handshake accepts it.

Each entry's identifier (its index plus one) is returned to the issue stage as the rename tag of the operation's destination. Tag zero is reserved to mean "value present". An entry stays occupied from issue until a broadcast carries its own tag, which is the moment its result is written. At that point the entry can take a new operation.

Top module: `rsv_station`

## Requirements
- R1: After reset no entry is occupied: `iss_full` is 0, `disp_valid` is 0 and `iss_tag` is 1.
- R2: An operation issued with both source tags equal to 0 is offered on the cycle after issue. The offer carries its opcode, both operand values, its immediate, and `disp_tag` equal to its own entry identifier.
- R3: An operand issued with a non-zero tag is held back. A later broadcast with `bc_valid`=1 and `bc_tag` equal to that tag loads `bc_value` into the operand. The entry is offered only once both of its tags are resolved.
- R4: When a broadcast matches an operand tag in the same cycle that the operation is issued, the broadcast value is captured at issue, and the entry does not wait on that tag.
- R5: Of several ready entries, the one with the lowest identifier is offered. At most one entry is accepted per cycle (`disp_valid`=1 and `disp_ready`=1). An accepted entry is never offered again.
- R6: An occupied entry is released when a broadcast carries its own identifier. The released slot is then available to the next issue.
- R7: `iss_full` is 1 exactly when every entry is occupied. An issue request while full is ignored and leaves no entry behind.
- R8: `iss_tag` gives the identifier that the next issue will receive: the lowest free entry index plus one. It is never 0 while a free entry exists.
- R9: A broadcast whose tag matches neither pending tag of an entry leaves that entry waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_qj | input | TAG_W | Producer tag of first operand, 0 if value given |
| iss_vj | input | DATA_W | First operand value |
| iss_qk | input | TAG_W | Producer tag of second operand, 0 if value given |
| iss_vk | input | DATA_W | Second operand value |
| iss_imm | input | IMM_W | Address or immediate field |
| iss_full | output | 1 | No free entry |
| iss_tag | output | TAG_W | Identifier the next issue receives |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready entry is offered |
| disp_ready | input | 1 | Functional unit accepts the offer |
| disp_tag | output | TAG_W | Identifier of the offered entry |
| disp_op | output | OP_W | Offered operation code |
| disp_vj | output | DATA_W | Offered first operand |
| disp_vk | output | DATA_W | Offered second operand |
| disp_imm | output | IMM_W | Offered immediate |

## Verification
The main path is first tried with a set of fully ready operations whose opcode, operand and immediate patterns differ. This shows whether every field travels through the entry without being mixed up. Operands that wait on a tag are then woken by a non-matching broadcast and then by a matching one, which separates a correct tag compare from a capture on any broadcast. A broadcast that lands in the issue cycle shows whether capture at issue is handled. A full station holding two waiting and two ready entries shows lowest-first selection, and shows that several entries wake on one broadcast. Issuing into that full station, and then releasing all its entries, shows that the refused issue left nothing behind.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   // tag value meaning "operand value is present"
   localparam int unsigned TAG_NONE = 0;

   // true when a valid broadcast carries the awaited, non-empty tag
   function automatic logic tag_hit(input logic valid, input int unsigned bus_tag,
                                    input int unsigned want);
      return valid && (want != TAG_NONE) && (bus_tag == want);
   endfunction
endpackage

// File: rtl/rsv_opnd.sv
module rsv_opnd #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [TAG_W-1:0]  iss_q,
   input  logic [DATA_W-1:0] iss_v,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   output logic [TAG_W-1:0]  q_o,
   output logic [DATA_W-1:0] v_o
);
   import rsv_pkg::*;

   logic hit_at_issue;
   logic hit_waiting;

   assign hit_at_issue = alloc && tag_hit(bc_valid, int'(bc_tag), int'(iss_q));
   assign hit_waiting  = !alloc && tag_hit(bc_valid, int'(bc_tag), int'(q_o));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
         v_o <= '0;
      end else if (alloc) begin
         q_o <= hit_at_issue ? '0 : iss_q;
         v_o <= hit_at_issue ? bc_value : iss_v;
      end else if (hit_waiting) begin
         q_o <= '0;
         v_o <= bc_value;
      end
   end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned OP_W   = 4,
   parameter int unsigned IMM_W  = 12,
   parameter int unsigned MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_qj,
   input  logic [DATA_W-1:0] iss_vj,
   input  logic [TAG_W-1:0]  iss_qk,
   input  logic [DATA_W-1:0] iss_vk,
   input  logic [IMM_W-1:0]  iss_imm,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   input  logic              start,
   output logic              busy_o,
   output logic              ready_o,
   output logic [OP_W-1:0]   op_o,
   output logic [DATA_W-1:0] vj_o,
   output logic [DATA_W-1:0] vk_o,
   output logic [IMM_W-1:0]  imm_o
);
   localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

   logic             started;
   logic [TAG_W-1:0] qj, qk;
   logic             release_me;

   rsv_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_j (
      .clk(clk), .rst_n(rst_n), .alloc(alloc), .iss_q(iss_qj), .iss_v(iss_vj),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .q_o(qj), .v_o(vj_o));

   rsv_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_k (
      .clk(clk), .rst_n(rst_n), .alloc(alloc), .iss_q(iss_qk), .iss_v(iss_vk),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .q_o(qk), .v_o(vk_o));

   assign release_me = busy_o && bc_valid && (bc_tag == SELF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o  <= 1'b0;
         started <= 1'b0;
         op_o    <= '0;
         imm_o   <= '0;
      end else if (alloc) begin
         busy_o  <= 1'b1;
         started <= 1'b0;
         op_o    <= iss_op;
         imm_o   <= iss_imm;
      end else begin
         if (release_me) busy_o <= 1'b0;
         if (start)      started <= 1'b1;
      end
   end

   assign ready_o = busy_o && !started && (qj == '0) && (qk == '0);
endmodule

// File: rtl/rsv_pick.sv
module rsv_pick #(
   parameter int unsigned N_REQ = 4,
   localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   // lowest set index wins
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N_REQ - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
   parameter int unsigned N_ENT  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned OP_W   = 4,
   parameter int unsigned IMM_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_qj,
   input  logic [DATA_W-1:0] iss_vj,
   input  logic [TAG_W-1:0]  iss_qk,
   input  logic [DATA_W-1:0] iss_vk,
   input  logic [IMM_W-1:0]  iss_imm,
   output logic              iss_full,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [TAG_W-1:0]  disp_tag,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_vj,
   output logic [DATA_W-1:0] disp_vk,
   output logic [IMM_W-1:0]  disp_imm
);
   localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

   if (N_ENT < 1) begin : g_bad_depth
      $error("rsv_station: N_ENT must be at least 1");
   end
   if (N_ENT + 1 > (1 << TAG_W)) begin : g_bad_tag
      $error("rsv_station: TAG_W too narrow for N_ENT identifiers plus the empty tag");
   end

   logic [N_ENT-1:0]  busy, ready, alloc_vec, start_vec;
   logic [OP_W-1:0]   e_op  [N_ENT];
   logic [DATA_W-1:0] e_vj  [N_ENT];
   logic [DATA_W-1:0] e_vk  [N_ENT];
   logic [IMM_W-1:0]  e_imm [N_ENT];

   logic             has_free, iss_fire, disp_fire;
   logic [IDX_W-1:0] free_idx, sel_idx;

   rsv_pick #(.N_REQ(N_ENT)) u_free_pick (.req(~busy), .any(has_free), .idx(free_idx));
   rsv_pick #(.N_REQ(N_ENT)) u_disp_pick (.req(ready), .any(disp_valid), .idx(sel_idx));

   assign iss_full  = !has_free;
   assign iss_tag   = has_free ? TAG_W'(free_idx) + TAG_W'(1) : '0;
   assign iss_fire  = iss_valid && has_free;
   assign disp_fire = disp_valid && disp_ready;

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      assign alloc_vec[g] = iss_fire && (free_idx == IDX_W'(g));
      assign start_vec[g] = disp_fire && (sel_idx == IDX_W'(g));

      rsv_entry #(
         .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .IMM_W(IMM_W), .MY_TAG(g + 1)
      ) u_ent (
         .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
         .iss_op(iss_op), .iss_qj(iss_qj), .iss_vj(iss_vj),
         .iss_qk(iss_qk), .iss_vk(iss_vk), .iss_imm(iss_imm),
         .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
         .start(start_vec[g]), .busy_o(busy[g]), .ready_o(ready[g]),
         .op_o(e_op[g]), .vj_o(e_vj[g]), .vk_o(e_vk[g]), .imm_o(e_imm[g]));
   end

   assign disp_tag = disp_valid ? TAG_W'(sel_idx) + TAG_W'(1) : '0;
   assign disp_op  = e_op[sel_idx];
   assign disp_vj  = e_vj[sel_idx];
   assign disp_vk  = e_vk[sel_idx];
   assign disp_imm = e_imm[sel_idx];
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
   parameter int unsigned N_ENT = 4,
   parameter int unsigned TAG_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_full,
   input logic [TAG_W-1:0] iss_tag,
   input logic             bc_valid,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic [TAG_W-1:0] disp_tag,
   input logic [N_ENT-1:0] busy
);
   // R8: a free slot always has a usable, non-empty identifier
   a_r8_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_full |-> (iss_tag != '0) && (int'(iss_tag) <= N_ENT));

   // R7: a full station stays full until a broadcast can release something
   a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      iss_full && !bc_valid |=> iss_full);

   // R5: an offer not taken stays up
   a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_ready |=> disp_valid);

   // R5: an untaken offer can only be displaced by a lower identifier
   a_r5_no_higher: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_ready |=> disp_tag <= $past(disp_tag));

   // R2: offers always name a real entry
   a_r2_offer_tag: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (disp_tag != '0) && (int'(disp_tag) <= N_ENT));

   // R7: at most one new entry per cycle
   a_r7_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $countones(busy) <= $countones($past(busy)) + 1);
endmodule

bind rsv_station rsv_station_chk #(.N_ENT(N_ENT), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_full(iss_full), .iss_tag(iss_tag),
   .bc_valid(bc_valid), .disp_valid(disp_valid), .disp_ready(disp_ready),
   .disp_tag(disp_tag), .busy(busy));

// File: tb/sim_rsv_station.sv
module sim_rsv_station;
   localparam int unsigned N_ENT = 4, DATA_W = 16, TAG_W = 3, OP_W = 4, IMM_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic iss_valid = 1'b0, bc_valid = 1'b0, disp_ready = 1'b0;
   logic [OP_W-1:0]   iss_op = '0;
   logic [TAG_W-1:0]  iss_qj = '0, iss_qk = '0, bc_tag = '0;
   logic [DATA_W-1:0] iss_vj = '0, iss_vk = '0, bc_value = '0;
   logic [IMM_W-1:0]  iss_imm = '0;
   logic              iss_full, disp_valid;
   logic [TAG_W-1:0]  iss_tag, disp_tag;
   logic [OP_W-1:0]   disp_op;
   logic [DATA_W-1:0] disp_vj, disp_vk;
   logic [IMM_W-1:0]  disp_imm;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rsv_station #(.N_ENT(N_ENT), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .IMM_W(IMM_W)) u0 (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk), .iss_imm(iss_imm),
      .iss_full(iss_full), .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
      .bc_value(bc_value), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_tag(disp_tag), .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk),
      .disp_imm(disp_imm));

   // ready operations: opcode, first value, second value, immediate
   localparam int NV = 5;
   localparam logic [OP_W-1:0]   V_OP  [NV] = '{4'h1, 4'hA, 4'h0, 4'hF, 4'h5};
   localparam logic [DATA_W-1:0] V_VJ  [NV] = '{16'h0001, 16'hFFFF, 16'h0000, 16'hA5A5, 16'h8000};
   localparam logic [DATA_W-1:0] V_VK  [NV] = '{16'h0002, 16'h0000, 16'hFFFF, 16'h5A5A, 16'h0001};
   localparam logic [IMM_W-1:0]  V_IMM [NV] = '{12'h000, 12'hFFF, 12'h123, 12'h800, 12'h07E};

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] qj,
                        input logic [DATA_W-1:0] vj, input logic [TAG_W-1:0] qk,
                        input logic [DATA_W-1:0] vk, input logic [IMM_W-1:0] imm);
      iss_valid = 1'b1; iss_op = op; iss_qj = qj; iss_vj = vj;
      iss_qk = qk; iss_vk = vk; iss_imm = imm;
      step();
      iss_valid = 1'b0; iss_qj = '0; iss_qk = '0;
   endtask

   task automatic bcast(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] val);
      bc_valid = 1'b1; bc_tag = tag; bc_value = val;
      step();
      bc_valid = 1'b0;
   endtask

   task automatic accept();
      disp_ready = 1'b1;
      step();
      disp_ready = 1'b0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 full", iss_full, 0);
      chk("R1 disp_valid", disp_valid, 0);
      chk("R1 iss_tag", iss_tag, 1);

      // R2 vector walk: ready operands pass intact to the unit
      for (int i = 0; i < NV; i++) begin
         issue(V_OP[i], 3'd0, V_VJ[i], 3'd0, V_VK[i], V_IMM[i]);
         chk("R2 valid", disp_valid, 1);
         chk("R2 tag", disp_tag, 1);
         chk("R2 op", disp_op, V_OP[i]);
         chk("R2 vj", disp_vj, V_VJ[i]);
         chk("R2 vk", disp_vk, V_VK[i]);
         chk("R2 imm", disp_imm, V_IMM[i]);
         accept();
         chk("R5 not re-offered", disp_valid, 0);
         bcast(3'd1, 16'h0);
         chk("R6 slot freed", iss_tag, 1);
      end

      // R3 and R9: waiting operand woken only by the matching tag
      issue(4'h3, 3'd3, 16'h0, 3'd0, 16'h0007, 12'h010);
      chk("R3 held", disp_valid, 0);
      chk("R8 next tag", iss_tag, 2);
      bcast(3'd4, 16'h0099);
      chk("R9 non-matching", disp_valid, 0);
      bcast(3'd3, 16'h0055);
      chk("R3 woken", disp_valid, 1);
      chk("R3 vj", disp_vj, 16'h0055);
      chk("R3 vk", disp_vk, 16'h0007);
      accept();
      bcast(3'd1, 16'h0);

      // R4: broadcast in the issue cycle is captured for both operands
      bc_valid = 1'b1; bc_tag = 3'd2; bc_value = 16'h1234;
      issue(4'h6, 3'd2, 16'h0, 3'd2, 16'h0, 12'h0);
      bc_valid = 1'b0;
      chk("R4 ready", disp_valid, 1);
      chk("R4 vj", disp_vj, 16'h1234);
      chk("R4 vk", disp_vk, 16'h1234);
      accept();
      bcast(3'd1, 16'h0);

      // R5, R7: fill the station, two entries waiting on tag 6
      issue(4'h1, 3'd6, 16'h0, 3'd0, 16'h0011, 12'h0);
      issue(4'h2, 3'd0, 16'h0022, 3'd0, 16'h0, 12'h0);
      chk("R8 third tag", iss_tag, 3);
      issue(4'h3, 3'd0, 16'h0, 3'd6, 16'h0, 12'h0);
      issue(4'h4, 3'd0, 16'h0044, 3'd0, 16'h0, 12'h0);
      chk("R7 full", iss_full, 1);
      issue(4'hE, 3'd0, 16'hDEAD, 3'd0, 16'hBEEF, 12'h0);
      chk("R5 lowest ready", disp_tag, 2);
      chk("R5 op", disp_op, 4'h2);
      accept();
      chk("R5 next ready", disp_tag, 4);
      accept();
      chk("R5 none left", disp_valid, 0);
      bcast(3'd6, 16'h0066);
      chk("R5 lowest after wake", disp_tag, 1);
      chk("R3 multi-wake vj", disp_vj, 16'h0066);
      accept();
      chk("R5 second woken", disp_tag, 3);
      chk("R3 multi-wake vk", disp_vk, 16'h0066);
      accept();
      bcast(3'd2, 16'h0);
      chk("R6 full released", iss_full, 0);
      chk("R8 freed slot", iss_tag, 2);
      bcast(3'd1, 16'h0);
      bcast(3'd3, 16'h0);
      bcast(3'd4, 16'h0);
      chk("R7 refused issue left nothing", disp_valid, 0);
      chk("R6 all free", iss_tag, 1);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule